// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer that turns a 32-bit virtual address into a physical address using 4 KB pages. Each of its 16 slots holds a virtual page number, an 8-bit address space tag, a shared flag, two permission bits, a physical page number and a valid flag. Only two address windows are translated: the lower half of the space and the window starting at 0xC0000000 that is 512 MB wide. Every other address bypasses the buffer and maps directly onto its low 29 bits.

A mode input changes how slots are matched. In isolated mode, private slots match only the current address space tag. This lets several processes share a virtual page number without a flush when the running process changes. In global mode, the tag plays no part in matching. A private slot with a matching page but a different tag is then reported as a protection fault. The block also reports more than one matching slot, a missing translation, and a breach of the permission bits. Software-style control loads or clears single slots, purges the whole buffer and sets the current tag. The block only raises flags; filling a slot after a miss and retrying the access are left to an outside handler.

Top module: `asid_tlb`

## Requirements
- R1: An address is translated only when bit 31 is 0 or bits 31:29 equal 110. For any other address the response has respTranslated=0, all four outcome flags at 0, and respPaddr = {3'b000, vaddr[28:0]}.
- R2: A request sampled at a clock edge produces respValid=1 with its result at that same edge, and respValid=0 after any edge where no request was sampled. A lookup uses the buffer contents as they stood before a write or purge in the same cycle.
- R3: When exactly one slot matches and no fault applies, respHit=1 and respPaddr = {slot PPN, vaddr[11:0]}.
- R4: For a translated address that no slot matches, respMiss=1 and respPaddr=0.
- R5: In isolated mode (modeIsolated=1), a private slot (shared=0) matches only when its tag equals the current tag, while a shared slot matches under any tag. Two slots may hold the same page under different tags and each is selected by its own tag.
- R6: In global mode (modeIsolated=0), the tag does not take part in matching. If the single matching slot is private and its tag differs from the current tag, respProtFault=1 and respPaddr=0.
- R7: When two or more valid slots match a translated address, respMultiHit=1 and respPaddr=0.
- R8: Permission bit 0 allows writes and bit 1 allows user access. A write request to a slot with bit 0 clear, or a user request to a slot with bit 1 clear, gives respProtFault=1 and respPaddr=0.
- R9: wrEn with wrInvalidate=0 loads the slot at wrIndex and marks it valid. wrEn with wrInvalidate=1 marks that slot invalid. purge invalidates every slot in one cycle and overrides a write issued in the same cycle.
- R10: asidWrEn loads the current tag from asidWrData, and the new tag is used from the next cycle on.
- R11: For a translated response, exactly one of respHit, respMiss, respMultiHit and respProtFault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeIsolated | input | 1 | 1 = isolated (tag-matched) mode, 0 = global mode |
| asidWrEn | input | 1 | Load the current address space tag |
| asidWrData | input | 8 | New current tag |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | The access is a write |
| reqUser | input | 1 | The access is from user level |
| wrEn | input | 1 | Slot write strobe |
| wrInvalidate | input | 1 | With wrEn, clear the slot instead of loading it |
| wrIndex | input | 4 | Slot to write |
| wrVpn | input | 20 | Virtual page number to load |
| wrAsid | input | 8 | Tag to load |
| wrShared | input | 1 | Shared flag to load |
| wrPerm | input | 2 | Permissions to load (bit 0 write, bit 1 user) |
| wrPpn | input | 20 | Physical page number to load |
| purge | input | 1 | Invalidate all slots |
| respValid | output | 1 | Result registered for the previous request |
| respTranslated | output | 1 | The address was in a translated window |
| respHit | output | 1 | Translation succeeded |
| respMiss | output | 1 | No slot matched |
| respMultiHit | output | 1 | More than one slot matched |
| respProtFault | output | 1 | Tag or permission fault |
| respPaddr | output | 32 | Physical address |

## Verification
A corrupted valid bit or slot field appears at the ports on the first lookup of that page. It shows up one edge after the request as a miss where a hit was due, as a wrong page number in respPaddr, or as a false multiple-match. A stale current tag shows the same way, in isolated mode as a miss and in global mode as a protection fault, on the first lookup after the tag write. The bench therefore loads slots whose pages collide on purpose and reads them under several tags and in both modes, so that every slot field and the tag register is observed through an outcome flag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_ENTRIES = 16;
  localparam int VA_W        = 32;
  localparam int PAGE_OFF_W  = 12;
  localparam int VPN_W       = VA_W - PAGE_OFF_W;
  localparam int PPN_W       = VA_W - PAGE_OFF_W;
  localparam int ASID_W      = 8;
  localparam int PERM_W      = 2;
  localparam int PERM_WR     = 0;
  localparam int PERM_USER   = 1;
  localparam int REGION_W    = 3;
  localparam logic [REGION_W-1:0] HIGH_XLAT_CODE = 3'b110;
  localparam int IDX_W       = $clog2(TLB_ENTRIES);
  localparam int CNT_W       = $clog2(TLB_ENTRIES + 1);

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic [PERM_W-1:0] perm;
    logic [PPN_W-1:0]  ppn;
  } tlbEntryT;

  typedef struct packed {
    logic                   purgeAll;
    logic                   loadEntry;
    logic                   clearEntry;
    logic                   loadAsid;
    logic                   capture;
    logic [TLB_ENTRIES-1:0] entrySel;
  } tlbStrobesT;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             wrEn,
  input  logic             wrInvalidate,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic             purge,
  input  logic             asidWrEn,
  output tlbStrobesT       strobes,
  output logic             respValid
);
  logic [TLB_ENTRIES-1:0] selDecode;

  for (genvar i = 0; i < TLB_ENTRIES; i++) begin : gSel
    assign selDecode[i] = (wrIndex == IDX_W'(i));
  end

  always_comb begin
    strobes.purgeAll   = purge;
    strobes.loadEntry  = wrEn && !wrInvalidate && !purge;
    strobes.clearEntry = wrEn &&  wrInvalidate && !purge;
    strobes.loadAsid   = asidWrEn;
    strobes.capture    = reqValid;
    strobes.entrySel   = selDecode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R2
  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEntry || strobes.clearEntry) |-> $onehot(strobes.entrySel)); // R9
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobesT        strobes,
  input  logic              modeIsolated,
  input  logic [ASID_W-1:0] asidWrData,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  tlbEntryT          newEntry,
  output logic              respTranslated,
  output logic              respHit,
  output logic              respMiss,
  output logic              respMultiHit,
  output logic              respProtFault,
  output logic [VA_W-1:0]   respPaddr
);
  logic [TLB_ENTRIES-1:0] validQ;
  tlbEntryT               entryQ [TLB_ENTRIES];
  logic [ASID_W-1:0]      curAsidQ;

  logic [VPN_W-1:0]       reqVpn;
  logic [TLB_ENTRIES-1:0] vpnHit;
  logic [TLB_ENTRIES-1:0] asidOk;
  logic [TLB_ENTRIES-1:0] matchVec;
  logic [CNT_W-1:0]       matchCount;
  logic [PPN_W-1:0]       selPpn;
  logic [PERM_W-1:0]      selPerm;
  logic                   selAsidBad;
  logic                   inXlatRegion;
  logic                   asidFault;
  logic                   permFault;

  logic                   nTrans, nHit, nMiss, nMulti, nProt;
  logic [VA_W-1:0]        nPaddr;

  // slot valid bits: purge wins over any slot write
  always_ff @(posedge clk) begin
    if (!rstN)                   validQ <= '0;
    else if (strobes.purgeAll)   validQ <= '0;
    else if (strobes.loadEntry)  validQ <= validQ | strobes.entrySel;
    else if (strobes.clearEntry) validQ <= validQ & ~strobes.entrySel;
  end

  for (genvar i = 0; i < TLB_ENTRIES; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        entryQ[i] <= '0;
      else if (strobes.loadEntry && strobes.entrySel[i])
        entryQ[i] <= newEntry;
    end

    assign vpnHit[i]   = validQ[i] && (entryQ[i].vpn == reqVpn);
    assign asidOk[i]   = entryQ[i].shared || (entryQ[i].asid == curAsidQ);
    assign matchVec[i] = vpnHit[i] && (!modeIsolated || asidOk[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 curAsidQ <= '0;
    else if (strobes.loadAsid) curAsidQ <= asidWrData;
  end

  assign reqVpn       = reqVaddr[VA_W-1:PAGE_OFF_W];
  assign inXlatRegion = !reqVaddr[VA_W-1] ||
                        (reqVaddr[VA_W-1:VA_W-REGION_W] == HIGH_XLAT_CODE);
  assign matchCount   = CNT_W'($countones(matchVec));

  // AND-OR select of the matching slot's fields
  always_comb begin
    selPpn     = '0;
    selPerm    = '0;
    selAsidBad = 1'b0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (matchVec[i]) begin
        selPpn  = selPpn  | entryQ[i].ppn;
        selPerm = selPerm | entryQ[i].perm;
        if (!asidOk[i]) selAsidBad = 1'b1;
      end
    end
  end

  assign asidFault = !modeIsolated && selAsidBad;
  assign permFault = (reqWrite && !selPerm[PERM_WR]) ||
                     (reqUser  && !selPerm[PERM_USER]);

  always_comb begin
    nTrans = inXlatRegion;
    nHit   = 1'b0;
    nMiss  = 1'b0;
    nMulti = 1'b0;
    nProt  = 1'b0;
    nPaddr = '0;
    if (!inXlatRegion) begin
      nPaddr = {{REGION_W{1'b0}}, reqVaddr[VA_W-REGION_W-1:0]};
    end else if (matchCount == '0) begin
      nMiss = 1'b1;
    end else if (matchCount != CNT_W'(1)) begin
      nMulti = 1'b1;
    end else if (asidFault || permFault) begin
      nProt = 1'b1;
    end else begin
      nHit   = 1'b1;
      nPaddr = {selPpn, reqVaddr[PAGE_OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respTranslated <= 1'b0;
      respHit        <= 1'b0;
      respMiss       <= 1'b0;
      respMultiHit   <= 1'b0;
      respProtFault  <= 1'b0;
      respPaddr      <= '0;
    end else if (strobes.capture) begin
      respTranslated <= nTrans;
      respHit        <= nHit;
      respMiss       <= nMiss;
      respMultiHit   <= nMulti;
      respProtFault  <= nProt;
      respPaddr      <= nPaddr;
    end
  end

  AST_PURGE_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.purgeAll |=> (validQ == '0)); // R9
  AST_LOAD_MARKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEntry && !strobes.purgeAll) |=>
      ((validQ & $past(strobes.entrySel)) == $past(strobes.entrySel))); // R9
  AST_ASID_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAsid |=> (curAsidQ == $past(asidWrData))); // R10
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respHit, respMiss, respMultiHit, respProtFault})); // R11
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !respTranslated |-> !(respHit || respMiss || respMultiHit || respProtFault)); // R1
  AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=>
      (!respHit || respPaddr[PAGE_OFF_W-1:0] == $past(reqVaddr[PAGE_OFF_W-1:0]))); // R3
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeIsolated,
  input  logic              asidWrEn,
  input  logic [ASID_W-1:0] asidWrData,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              wrEn,
  input  logic              wrInvalidate,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrShared,
  input  logic [PERM_W-1:0] wrPerm,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic              purge,
  output logic              respValid,
  output logic              respTranslated,
  output logic              respHit,
  output logic              respMiss,
  output logic              respMultiHit,
  output logic              respProtFault,
  output logic [VA_W-1:0]   respPaddr
);
  tlbStrobesT strobes;
  tlbEntryT   newEntry;

  assign newEntry = '{vpn: wrVpn, asid: wrAsid, shared: wrShared,
                      perm: wrPerm, ppn: wrPpn};

  tlb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .wrEn         (wrEn),
    .wrInvalidate (wrInvalidate),
    .wrIndex      (wrIndex),
    .purge        (purge),
    .asidWrEn     (asidWrEn),
    .strobes      (strobes),
    .respValid    (respValid)
  );

  tlb_datapath u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .modeIsolated   (modeIsolated),
    .asidWrData     (asidWrData),
    .reqVaddr       (reqVaddr),
    .reqWrite       (reqWrite),
    .reqUser        (reqUser),
    .newEntry       (newEntry),
    .respTranslated (respTranslated),
    .respHit        (respHit),
    .respMiss       (respMiss),
    .respMultiHit   (respMultiHit),
    .respProtFault  (respProtFault),
    .respPaddr      (respPaddr)
  );
endmodule

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeIsolated = 1'b1;
  logic        asidWrEn = 1'b0;
  logic [7:0]  asidWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrInvalidate = 1'b0;
  logic [3:0]  wrIndex = '0;
  logic [19:0] wrVpn = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrShared = 1'b0;
  logic [1:0]  wrPerm = '0;
  logic [19:0] wrPpn = '0;
  logic        purge = 1'b0;
  logic        respValid, respTranslated, respHit, respMiss, respMultiHit, respProtFault;
  logic [31:0] respPaddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // outcome codes {translated, hit, miss, multi, prot}
  localparam logic [4:0] O_BYPASS = 5'b00000;
  localparam logic [4:0] O_HIT    = 5'b11000;
  localparam logic [4:0] O_MISS   = 5'b10100;
  localparam logic [4:0] O_MULTI  = 5'b10010;
  localparam logic [4:0] O_PROT   = 5'b10001;

  always #10 clk = ~clk;

  asid_tlb u_dut (.*);

  task automatic check(input string tag, input logic [4:0] expO, input logic [31:0] expPa);
    logic [4:0] act;
    act = {respTranslated, respHit, respMiss, respMultiHit, respProtFault};
    checks++;
    if (respValid !== 1'b1 || act !== expO || respPaddr !== expPa) begin
      errors++;
      $display("FAIL %s: valid=%b flags=%b paddr=%h expected valid=1 flags=%b paddr=%h",
               tag, respValid, act, respPaddr, expO, expPa);
    end
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input logic wr, input logic usr,
                        input logic [4:0] expO, input logic [31:0] expPa);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, expO, expPa);
  endtask

  task automatic writeSlot(input logic [3:0] idx, input logic [19:0] vpn, input logic [7:0] asid,
                           input logic sh, input logic [1:0] perm, input logic [19:0] ppn);
    @(negedge clk);
    wrEn = 1'b1; wrInvalidate = 1'b0; wrIndex = idx; wrVpn = vpn;
    wrAsid = asid; wrShared = sh; wrPerm = perm; wrPpn = ppn;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearSlot(input logic [3:0] idx);
    @(negedge clk);
    wrEn = 1'b1; wrInvalidate = 1'b1; wrIndex = idx;
    @(negedge clk);
    wrEn = 1'b0; wrInvalidate = 1'b0;
  endtask

  task automatic setAsid(input logic [7:0] a);
    @(negedge clk);
    asidWrEn = 1'b1; asidWrData = a;
    @(negedge clk);
    asidWrEn = 1'b0;
  endtask

  task automatic testReset();
    checks++;
    if (respValid !== 1'b0 || respHit !== 1'b0 || respMiss !== 1'b0 || respPaddr !== 32'h0) begin
      errors++;
      $display("FAIL R2 reset: valid=%b hit=%b miss=%b paddr=%h expected all zero",
               respValid, respHit, respMiss, respPaddr);
    end
    lookup("R4 empty buffer", 32'h0001_2345, 0, 0, O_MISS, 32'h0);
  endtask

  task automatic testRegions();
    lookup("R1 bypass 0x8", 32'h8123_4567, 0, 0, O_BYPASS, 32'h0123_4567);
    lookup("R1 bypass 0xA", 32'hA000_0010, 0, 0, O_BYPASS, 32'h0000_0010);
    lookup("R1 bypass 0xE", 32'hE000_0004, 0, 0, O_BYPASS, 32'h0000_0004);
    lookup("R1 high window translated", 32'hC000_1000, 0, 0, O_MISS, 32'h0);
  endtask

  task automatic testHit();
    modeIsolated = 1'b1;
    setAsid(8'd5);
    writeSlot(4'd3, 20'h00012, 8'd5, 1'b0, 2'b11, 20'hABCDE);
    writeSlot(4'd4, 20'hC0040, 8'd1, 1'b1, 2'b11, 20'h11111);
    lookup("R3 low window hit", 32'h0001_2345, 0, 1, O_HIT, 32'hABCD_E345);
    lookup("R3 high window hit", 32'hC004_0ABC, 1, 0, O_HIT, 32'h1111_1ABC);
    lookup("R4 other page miss", 32'h0001_3000, 0, 0, O_MISS, 32'h0);
  endtask

  task automatic testIsolated();
    writeSlot(4'd5, 20'h00012, 8'd7, 1'b0, 2'b11, 20'h22222);
    lookup("R5 tag 5 picks own slot", 32'h0001_2345, 0, 0, O_HIT, 32'hABCD_E345);
    setAsid(8'd7);
    lookup("R10 R5 tag 7 picks other slot", 32'h0001_2345, 0, 0, O_HIT, 32'h2222_2345);
    setAsid(8'd9);
    lookup("R5 unknown tag misses", 32'h0001_2345, 0, 0, O_MISS, 32'h0);
    lookup("R5 shared slot any tag", 32'hC004_0001, 0, 0, O_HIT, 32'h1111_1001);
  endtask

  task automatic testGlobal();
    clearSlot(4'd5);
    modeIsolated = 1'b0;
    lookup("R6 foreign private slot faults", 32'h0001_2345, 0, 0, O_PROT, 32'h0);
    setAsid(8'd5);
    lookup("R6 own tag hits", 32'h0001_2345, 0, 0, O_HIT, 32'hABCD_E345);
    setAsid(8'd9);
    lookup("R6 shared slot no fault", 32'hC004_0002, 0, 0, O_HIT, 32'h1111_1002);
  endtask

  task automatic testMulti();
    setAsid(8'd5);
    writeSlot(4'd5, 20'h00012, 8'd7, 1'b0, 2'b11, 20'h22222);
    lookup("R7 global duplicate page", 32'h0001_2345, 0, 0, O_MULTI, 32'h0);
    modeIsolated = 1'b1;
    lookup("R7 isolated resolves by tag", 32'h0001_2345, 0, 0, O_HIT, 32'hABCD_E345);
    writeSlot(4'd6, 20'h00012, 8'd5, 1'b0, 2'b11, 20'h33333);
    lookup("R7 isolated duplicate", 32'h0001_2345, 0, 0, O_MULTI, 32'h0);
    clearSlot(4'd6);
  endtask

  task automatic testPerm();
    writeSlot(4'd7, 20'h00300, 8'd5, 1'b0, 2'b10, 20'h44444);
    writeSlot(4'd8, 20'h00301, 8'd5, 1'b0, 2'b01, 20'h55555);
    lookup("R8 user read allowed", 32'h0030_0010, 0, 1, O_HIT, 32'h4444_4010);
    lookup("R8 write denied", 32'h0030_0010, 1, 0, O_PROT, 32'h0);
    lookup("R8 user denied", 32'h0030_1020, 0, 1, O_PROT, 32'h0);
    lookup("R8 supervisor write allowed", 32'h0030_1020, 1, 0, O_HIT, 32'h5555_5020);
  endtask

  task automatic testWritePort();
    clearSlot(4'd7);
    lookup("R9 cleared slot misses", 32'h0030_0010, 0, 1, O_MISS, 32'h0);
    lookup("R9 neighbour kept", 32'h0030_1020, 1, 0, O_HIT, 32'h5555_5020);
    @(negedge clk);
    purge = 1'b1;
    wrEn = 1'b1; wrInvalidate = 1'b0; wrIndex = 4'd9; wrVpn = 20'h00400;
    wrAsid = 8'd5; wrShared = 1'b1; wrPerm = 2'b11; wrPpn = 20'h66666;
    @(negedge clk);
    purge = 1'b0; wrEn = 1'b0;
    lookup("R9 purge clears", 32'h0001_2345, 0, 0, O_MISS, 32'h0);
    lookup("R9 purge beats write", 32'h0040_0000, 0, 0, O_MISS, 32'h0);
    lookup("R9 purge clears shared", 32'hC004_0000, 0, 0, O_MISS, 32'h0);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    wrEn = 1'b1; wrInvalidate = 1'b0; wrIndex = 4'd0; wrVpn = 20'h00050;
    wrAsid = 8'd5; wrShared = 1'b0; wrPerm = 2'b11; wrPpn = 20'h77777;
    reqValid = 1'b1; reqVaddr = 32'h0005_0123; reqWrite = 1'b0; reqUser = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    check("R2 lookup sees old contents", O_MISS, 32'h0);
    @(negedge clk);
    checks++;
    if (respValid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle cycle: respValid=%b expected 0", respValid);
    end
    lookup("R2 write visible next cycle", 32'h0005_0123, 0, 0, O_HIT, 32'h7777_7123);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegions();
    testHit();
    testIsolated();
    testGlobal();
    testMulti();
    testPerm();
    testWritePort();
    testSameCycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule